// File: doc/BRIEF.md
# Pointer Masking Address Transform

This block sits on the data-address path of a 64-bit core, after the effective address is formed and before address translation. It removes software tag bits from the upper part of a data address. If masking is enabled for the privilege level that governs the access, the top 7 or 16 bits are overwritten. Under paged translation they become copies of the highest kept bit. Under bare addressing they are cleared. Instruction fetches and accesses with masking disabled pass through unchanged. A non-canonical address is therefore left for the translation stage to fault on.

The configuration that applies depends on the access. Ordinarily it is the current privilege level's own configuration. When machine mode has its modify-privilege bit set, a data access uses the previous-privilege field instead. The result appears on a registered output, together with a copy used as the faulting address that gets reported, so a trap never exposes the raw tagged value. The transform works on the base address only. Wrap-around of a misaligned access near the top of the address space is handled by the access-splitting logic. If `XLEN` is not 64, the block ties the output to the input.

Top module: `pm_addr_xform`

## Requirements
- R1: While `rst` is high at a clock edge, both outputs become all zeros.
- R2: Each per-privilege config field is decoded as follows: 2'b00 means off, 2'b01 is reserved and treated as off, 2'b10 masks the top 7 bits, and 2'b11 masks the top 16 bits.
- R3: An access with `acc_kind_i` = 2'b00 (instruction fetch) is never modified. Loads (2'b01), stores (2'b10) and cache-management operations (2'b11) are subject to masking.
- R4: When the governing privilege is not machine mode and `satp_mode_i` is nonzero (paged), a 16-bit mask sets bits 63:48 to copies of bit 47. For example, 0x0000900000000000 becomes 0xFFFF900000000000.
- R5: Under the conditions of R4, a 7-bit mask sets bits 63:57 to copies of bit 56.
- R6: When `satp_mode_i` is 0, or the governing privilege is machine mode (2'b11), the masked bits are cleared instead of copied.
- R7: With masking off, the address, including any non-canonical upper field, passes through unchanged.
- R8: The governing privilege is `priv_i`, encoded as U = 2'b00, S = 2'b01 and M = 2'b11. It selects `cfg_u_i`, `cfg_s_i` or `cfg_m_i`.
- R9: When `priv_i` is M, `mprv_i` is 1 and the access is not a fetch, the privilege in `mpp_i` governs both the config choice and the fill rule.
- R10: `fault_addr_o` always equals `addr_o`, which is the transformed address.
- R11: Each result appears one clock after its inputs are sampled. Bits 47:0 are never altered.
- R12: The transform adds nothing, so there is no carry or wrap. For example, 0xFFFFFFFFFFFFFFFA with a 16-bit mask is unchanged under paged translation and becomes 0x0000FFFFFFFFFFFA under bare addressing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 64 | Raw effective address |
| priv_i | input | 2 | Current privilege (U=00, S=01, M=11) |
| mprv_i | input | 1 | Modify-privilege bit for machine-mode data accesses |
| mpp_i | input | 2 | Previous privilege field |
| cfg_u_i | input | 2 | Mask config for user mode |
| cfg_s_i | input | 2 | Mask config for supervisor mode |
| cfg_m_i | input | 2 | Mask config for machine mode |
| satp_mode_i | input | 4 | Translation mode (0 = bare, nonzero = paged) |
| acc_kind_i | input | 2 | Access kind: fetch, load, store, cache op |
| addr_o | output | 64 | Transformed address |
| fault_addr_o | output | 64 | Address reported on a fault |

## Verification
Each result is due exactly one rising edge after its inputs are applied. The bench changes inputs on a falling edge and reads both outputs on the following falling edge, after a single rising edge has passed. One latency check reads the outputs before that rising edge to confirm they still hold the previous result. The reset check also reads on a falling edge, after two rising edges with reset held.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_CMO   = 2'b11
  } pm_acc_e;

  typedef enum logic [1:0] {
    PMC_OFF   = 2'b00,
    PMC_RSVD  = 2'b01,
    PMC_SHORT = 2'b10,
    PMC_LONG  = 2'b11
  } pm_cfg_e;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef struct packed {
    logic active;
    logic long_len;
    logic sign_ext;
  } pm_ctl_t;

endpackage

// File: rtl/pm_ctl_select.sv
module pm_ctl_select
  import pm_pkg::*;
(
  input  logic [1:0] priv_i,
  input  logic       mprv_i,
  input  logic [1:0] mpp_i,
  input  logic [1:0] cfg_u_i,
  input  logic [1:0] cfg_s_i,
  input  logic [1:0] cfg_m_i,
  input  logic [3:0] satp_mode_i,
  input  logic [1:0] acc_kind_i,
  output pm_ctl_t    ctl_o
);

  logic       is_data;
  logic [1:0] eff_priv;
  pm_cfg_e    eff_cfg;

  always_comb begin
    is_data  = (pm_acc_e'(acc_kind_i) != ACC_FETCH);
    eff_priv = (priv_i == PRIV_M && mprv_i && is_data) ? mpp_i : priv_i;
    unique case (eff_priv)
      PRIV_S:  eff_cfg = pm_cfg_e'(cfg_s_i);
      PRIV_M:  eff_cfg = pm_cfg_e'(cfg_m_i);
      default: eff_cfg = pm_cfg_e'(cfg_u_i);
    endcase
    ctl_o.active   = is_data && (eff_cfg == PMC_SHORT || eff_cfg == PMC_LONG);
    ctl_o.long_len = (eff_cfg == PMC_LONG);
    ctl_o.sign_ext = (eff_priv != PRIV_M) && (satp_mode_i != 4'd0);
  end

endmodule

// File: rtl/pm_xform.sv
module pm_xform
  import pm_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LEN_SHORT = 7,
  parameter int LEN_LONG  = 16
) (
  input  logic [XLEN-1:0] addr_i,
  input  pm_ctl_t         ctl_i,
  output logic [XLEN-1:0] addr_o
);

  localparam int KEEP_S = XLEN - LEN_SHORT;
  localparam int KEEP_L = XLEN - LEN_LONG;

  logic [LEN_SHORT-1:0] fill_s;
  logic [LEN_LONG-1:0]  fill_l;

  always_comb begin
    fill_s = ctl_i.sign_ext ? {LEN_SHORT{addr_i[KEEP_S-1]}} : '0;
    fill_l = ctl_i.sign_ext ? {LEN_LONG{addr_i[KEEP_L-1]}} : '0;
    addr_o = addr_i;
    if (ctl_i.active) begin
      if (ctl_i.long_len) addr_o = {fill_l, addr_i[KEEP_L-1:0]};
      else                addr_o = {fill_s, addr_i[KEEP_S-1:0]};
    end
  end

endmodule

// File: rtl/pm_addr_xform.sv
module pm_addr_xform
  import pm_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int LEN_SHORT = 7,
  parameter int LEN_LONG  = 16,
  parameter bit OUT_REG   = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] addr_i,
  input  logic [1:0]      priv_i,
  input  logic            mprv_i,
  input  logic [1:0]      mpp_i,
  input  logic [1:0]      cfg_u_i,
  input  logic [1:0]      cfg_s_i,
  input  logic [1:0]      cfg_m_i,
  input  logic [3:0]      satp_mode_i,
  input  logic [1:0]      acc_kind_i,
  output logic [XLEN-1:0] addr_o,
  output logic [XLEN-1:0] fault_addr_o
);

  logic [XLEN-1:0] xf_addr;
  pm_ctl_t         ctl;

  pm_ctl_select u_sel (
    .priv_i      (priv_i),
    .mprv_i      (mprv_i),
    .mpp_i       (mpp_i),
    .cfg_u_i     (cfg_u_i),
    .cfg_s_i     (cfg_s_i),
    .cfg_m_i     (cfg_m_i),
    .satp_mode_i (satp_mode_i),
    .acc_kind_i  (acc_kind_i),
    .ctl_o       (ctl)
  );

  generate
    if (XLEN == 64) begin : g_rv64
      pm_xform #(
        .XLEN      (XLEN),
        .LEN_SHORT (LEN_SHORT),
        .LEN_LONG  (LEN_LONG)
      ) u_xf (
        .addr_i (addr_i),
        .ctl_i  (ctl),
        .addr_o (xf_addr)
      );
    end else begin : g_tie
      assign xf_addr = addr_i;
    end

    if (OUT_REG) begin : g_reg
      logic [XLEN-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= xf_addr;
      end
      assign addr_o       = out_q;
      assign fault_addr_o = out_q;
    end else begin : g_comb
      assign addr_o       = xf_addr;
      assign fault_addr_o = xf_addr;
    end
  endgenerate

endmodule

// File: rtl/pm_addr_xform_chk.sv
module pm_addr_xform_chk #(
  parameter int XLEN     = 64,
  parameter int LEN_LONG = 16
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] addr_i,
  input logic [1:0]      priv_i,
  input logic [1:0]      cfg_u_i,
  input logic [3:0]      satp_mode_i,
  input logic [1:0]      acc_kind_i,
  input logic [XLEN-1:0] addr_o,
  input logic [XLEN-1:0] fault_addr_o
);

  localparam int KEEP_L = XLEN - LEN_LONG;

  logic live;
  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R10
  fault_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> fault_addr_o == addr_o);

  // R3
  fetch_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(acc_kind_i) == 2'b00) |-> addr_o == $past(addr_i));

  // R11
  low_keep_chk: assert property (@(posedge clk) disable iff (rst)
    live |-> addr_o[KEEP_L-1:0] == $past(addr_i[KEEP_L-1:0]));

  // R7
  user_off_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(priv_i == 2'b00 && cfg_u_i[1] == 1'b0)) |-> addr_o == $past(addr_i));

  // R4
  user_long_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(priv_i == 2'b00 && cfg_u_i == 2'b11 && acc_kind_i != 2'b00 && satp_mode_i != 4'd0))
      |-> addr_o[XLEN-1:KEEP_L] == {LEN_LONG{$past(addr_i[KEEP_L-1])}});

endmodule

bind pm_addr_xform pm_addr_xform_chk #(
  .XLEN     (XLEN),
  .LEN_LONG (LEN_LONG)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .addr_i       (addr_i),
  .priv_i       (priv_i),
  .cfg_u_i      (cfg_u_i),
  .satp_mode_i  (satp_mode_i),
  .acc_kind_i   (acc_kind_i),
  .addr_o       (addr_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/pm_addr_xform_tb_top.sv
module pm_addr_xform_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] addr_i = 64'hDEAD_BEEF_0000_1111;
  logic [1:0]  priv_i = 2'b00;
  logic        mprv_i = 1'b0;
  logic [1:0]  mpp_i = 2'b00;
  logic [1:0]  cfg_u_i = 2'b00;
  logic [1:0]  cfg_s_i = 2'b00;
  logic [1:0]  cfg_m_i = 2'b00;
  logic [3:0]  satp_mode_i = 4'd9;
  logic [1:0]  acc_kind_i = 2'b01;
  logic [63:0] addr_o;
  logic [63:0] fault_addr_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pm_addr_xform dut_i (
    .clk          (clk),
    .rst          (rst),
    .addr_i       (addr_i),
    .priv_i       (priv_i),
    .mprv_i       (mprv_i),
    .mpp_i        (mpp_i),
    .cfg_u_i      (cfg_u_i),
    .cfg_s_i      (cfg_s_i),
    .cfg_m_i      (cfg_m_i),
    .satp_mode_i  (satp_mode_i),
    .acc_kind_i   (acc_kind_i),
    .addr_o       (addr_o),
    .fault_addr_o (fault_addr_o)
  );

  task automatic check(input logic [63:0] exp, input string tag);
    n_checks++;
    if (addr_o !== exp || fault_addr_o !== exp) begin
      n_fail++;
      $display("FAIL %s: addr_o=%h fault_addr_o=%h expected %h", tag, addr_o, fault_addr_o, exp);
    end
  endtask

  // Apply inputs on a falling edge, let one rising edge pass, read on the next falling edge.
  task automatic apply(input logic [1:0] pv, input logic mp, input logic [1:0] pp,
                       input logic [3:0] sm, input logic [1:0] ak, input logic [63:0] a);
    @(negedge clk);
    priv_i = pv; mprv_i = mp; mpp_i = pp; satp_mode_i = sm; acc_kind_i = ak; addr_i = a;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(64'h0, "R1 reset");
    rst = 1'b0;
  endtask

  task automatic t_encoding();
    cfg_u_i = 2'b00; apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'hABAB_5000_0000_0000, "R2 cfg off");
    cfg_u_i = 2'b01; apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'hABAB_5000_0000_0000, "R2 cfg reserved");
    cfg_u_i = 2'b10; apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'hFFAB_5000_0000_0000, "R2 cfg short");
    cfg_u_i = 2'b11; apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'h0000_5000_0000_0000, "R2 cfg long");
  endtask

  task automatic t_long();
    cfg_u_i = 2'b11;
    apply(2'b00, 0, 0, 4'd9, 2'b01, 64'h0000_9000_0000_0000);
    check(64'hFFFF_9000_0000_0000, "R4 sign copy of bit 47");
    apply(2'b00, 0, 0, 4'd8, 2'b10, 64'hAA00_0000_1234_5678);
    check(64'h0000_0000_1234_5678, "R4 tagged equals untagged");
  endtask

  task automatic t_short();
    cfg_u_i = 2'b10;
    apply(2'b00, 0, 0, 4'd9, 2'b01, 64'h0100_0000_0000_1234);
    check(64'hFF00_0000_0000_1234, "R5 short bit56 set");
    apply(2'b00, 0, 0, 4'd10, 2'b01, 64'hFE00_0000_0000_1234);
    check(64'h0000_0000_0000_1234, "R5 short bit56 clear");
  endtask

  task automatic t_bare();
    cfg_u_i = 2'b11;
    apply(2'b00, 0, 0, 4'd0, 2'b01, 64'h0000_9000_0000_0000);
    check(64'h0000_9000_0000_0000, "R6 bare zero fill");
    apply(2'b00, 0, 0, 4'd0, 2'b01, 64'hAA00_0000_1234_5678);
    check(64'h0000_0000_1234_5678, "R6 bare tag cleared");
    cfg_m_i = 2'b11;
    apply(2'b11, 0, 0, 4'd9, 2'b01, 64'hFFFF_9000_0000_0000);
    check(64'h0000_9000_0000_0000, "R6 machine mode zero fill");
    cfg_m_i = 2'b00;
  endtask

  task automatic t_disabled();
    cfg_s_i = 2'b00;
    apply(2'b01, 0, 0, 4'd9, 2'b01, 64'hAA00_0000_1234_5678);
    check(64'hAA00_0000_1234_5678, "R7 off keeps non-canonical");
  endtask

  task automatic t_kind();
    cfg_u_i = 2'b11;
    apply(2'b00, 0, 0, 4'd9, 2'b00, 64'hABAB_5000_0000_0000);
    check(64'hABAB_5000_0000_0000, "R3 fetch untouched");
    apply(2'b00, 0, 0, 4'd9, 2'b10, 64'hABAB_5000_0000_0000);
    check(64'h0000_5000_0000_0000, "R3 store masked");
    apply(2'b00, 0, 0, 4'd9, 2'b11, 64'hABAB_5000_0000_0000);
    check(64'h0000_5000_0000_0000, "R3 cache op masked");
  endtask

  task automatic t_priv();
    cfg_u_i = 2'b00; cfg_s_i = 2'b11; cfg_m_i = 2'b10;
    apply(2'b01, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'h0000_5000_0000_0000, "R8 S uses its config");
    apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'hABAB_5000_0000_0000, "R8 U uses its config");
    apply(2'b11, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    check(64'h01AB_5000_0000_0000, "R8 M uses its config");
  endtask

  task automatic t_mprv();
    cfg_u_i = 2'b00; cfg_s_i = 2'b11; cfg_m_i = 2'b00;
    apply(2'b11, 1, 2'b01, 4'd9, 2'b01, 64'h0000_9000_0000_0000);
    check(64'hFFFF_9000_0000_0000, "R9 MPRV uses S config and paging");
    apply(2'b11, 0, 2'b01, 4'd9, 2'b01, 64'h0000_9000_0000_0000);
    check(64'h0000_9000_0000_0000, "R9 MPRV clear uses M config");
    apply(2'b11, 1, 2'b01, 4'd9, 2'b00, 64'h0000_9000_0000_0000);
    check(64'h0000_9000_0000_0000, "R9 MPRV ignored for fetch");
    apply(2'b11, 1, 2'b00, 4'd9, 2'b01, 64'hAA00_0000_1234_5678);
    check(64'hAA00_0000_1234_5678, "R9 MPRV with U previous");
  endtask

  task automatic t_fault();
    cfg_u_i = 2'b11;
    apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hABAB_5000_0000_0000);
    n_checks++;
    if (fault_addr_o !== 64'h0000_5000_0000_0000) begin
      n_fail++;
      $display("FAIL R10 fault addr: %h expected %h", fault_addr_o, 64'h0000_5000_0000_0000);
    end
  endtask

  task automatic t_wrap();
    cfg_u_i = 2'b11;
    apply(2'b00, 0, 0, 4'd9, 2'b01, 64'hFFFF_FFFF_FFFF_FFFA);
    check(64'hFFFF_FFFF_FFFF_FFFA, "R12 paged top of space");
    apply(2'b00, 0, 0, 4'd0, 2'b01, 64'hFFFF_FFFF_FFFF_FFFA);
    check(64'h0000_FFFF_FFFF_FFFA, "R12 bare no carry");
  endtask

  task automatic t_latency();
    cfg_u_i = 2'b11;
    apply(2'b00, 0, 0, 4'd9, 2'b01, 64'h1234_0000_0000_0042);
    check(64'h0000_0000_0000_0042, "R11 first result");
    addr_i = 64'h0000_8000_0000_0001;
    #1;
    check(64'h0000_0000_0000_0042, "R11 holds before edge");
    @(negedge clk);
    check(64'hFFFF_8000_0000_0001, "R11 one edge later");
  endtask

  initial begin
    t_reset();
    t_encoding();
    t_long();
    t_short();
    t_bare();
    t_disabled();
    t_kind();
    t_priv();
    t_mprv();
    t_fault();
    t_wrap();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule